// File: doc/BRIEF.md
# Privileged Region Guard

This block enforces memory protection for the running process. The process owns one contiguous physical region, described by a lower-limit register and an upper-limit register. Every program access is presented on the check port with its address and privilege mode. The block answers in the same cycle with either a permit or a fault. User-mode accesses are permitted only inside the region. Supervisor-mode accesses are not range-checked.

Both limit registers are visible through a small register port. Software in either privilege mode can read them. Only supervisor-mode writes change them. A user-mode write is refused, leaves the registers untouched, and raises a one-cycle privilege-violation pulse. After reset both limits are zero, so every user access faults until supervisor software sets up the region.

Top module: `region_guard`

## Requirements
- R1: After reset both limit registers read 0, privFault is low, and every valid user-mode check faults.
- R2: A supervisor write (regReq=1, regWrite=1, regMode=1) with regSel=0 loads regWdata into the lower limit at that clock edge.
- R3: A supervisor write with regSel=1 loads regWdata into the upper limit at that clock edge.
- R4: regRdata shows the lower limit when regSel=0 and the upper limit when regSel=1, in the same cycle, whatever regMode is.
- R5: A user-mode write (regMode=0) leaves both limit registers unchanged.
- R6: privFault is high for exactly the one cycle after the edge that took a user-mode write request. Supervisor writes and reads of either mode never raise it.
- R7: A valid user-mode check (chkMode=0) is permitted if and only if lower <= chkAddr < upper, with unsigned compare. Otherwise it faults.
- R8: A valid supervisor-mode check (chkMode=1) is always permitted, whatever the limits are.
- R9: When chkValid is low, both chkPermit and chkFault are low.
- R10: chkPermit and chkFault are never high together. When chkValid is high, exactly one of them is high.
- R11: A check made in the same cycle as a limit write uses the old limits. The new limits apply to checks from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regReq | input | 1 | Register port request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regSel | input | 1 | 0 = lower limit, 1 = upper limit |
| regMode | input | 1 | Requester mode: 1 = supervisor, 0 = user |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Selected limit register |
| privFault | output | 1 | One-cycle pulse after a refused user write |
| chkValid | input | 1 | Access check request |
| chkMode | input | 1 | Access mode: 1 = supervisor, 0 = user |
| chkAddr | input | 32 | Access address |
| chkPermit | output | 1 | Access allowed |
| chkFault | output | 1 | Access refused |

## Verification
The check result and the read data are combinational. The bench therefore samples them one nanosecond after it drives inputs at the falling edge, in that same cycle. A limit write takes effect at the next rising edge. The bench updates its model of the limits only after that edge, and it checks an access driven alongside a write against the old limits. privFault is registered. The bench samples it at the falling edge after the request's rising edge, expecting the pulse there. It then expects privFault low again one cycle later.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;
  typedef enum logic {PRIV_USER = 1'b0, PRIV_SUPER = 1'b1} privMode_e;
  typedef enum logic {SLOT_LOWER = 1'b0, SLOT_UPPER = 1'b1} slot_e;
  localparam int NUM_SLOTS = 2;

  typedef struct packed {
    logic wrUpper;
    logic wrLower;
    logic denyWrite;
  } regStrobe_t;
endpackage

// File: rtl/region_guard_ctrl.sv
module region_guard_ctrl
  import region_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regReq,
  input  logic       regWrite,
  input  logic       regSel,
  input  logic       regMode,
  output regStrobe_t strobe,
  output logic       privFault
);
  privMode_e reqMode;
  slot_e     reqSlot;
  logic      isWrite;

  assign reqMode = privMode_e'(regMode);
  assign reqSlot = slot_e'(regSel);
  assign isWrite = regReq && regWrite;

  always_comb begin
    strobe = '0;
    if (isWrite) begin
      if (reqMode == PRIV_SUPER) begin
        strobe.wrLower = (reqSlot == SLOT_LOWER);
        strobe.wrUpper = (reqSlot == SLOT_UPPER);
      end else begin
        strobe.denyWrite = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) privFault <= 1'b0;
    else       privFault <= strobe.denyWrite;
  end

  // R6: a pulse appears only after a user-mode write request
  a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(privFault) |-> $past(regReq && regWrite && !regMode));

  // R6: supervisor traffic never produces the pulse
  a_r6_super_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regMode) |=> !privFault);

  // R5: a refused write never also raises a load strobe
  a_r5_no_load_on_deny: assert property (@(posedge clk) disable iff (!rstN)
    strobe.denyWrite |-> !(strobe.wrLower || strobe.wrUpper));
endmodule

// File: rtl/region_guard_dp.sv
module region_guard_dp
  import region_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic              regSel,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  input  logic              chkValid,
  input  logic              chkMode,
  input  logic [ADDR_W-1:0] chkAddr,
  output logic              chkPermit,
  output logic              chkFault
);
  localparam logic [ADDR_W-1:0] RESET_LIMIT = '0;

  logic [NUM_SLOTS-1:0] slotWr;
  logic [ADDR_W-1:0]    slotQ [NUM_SLOTS];
  logic [ADDR_W-1:0]    lowerQ, upperQ;
  logic                 inRange;

  assign slotWr = {strobe.wrUpper, strobe.wrLower};

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          slotQ[g] <= RESET_LIMIT;
      else if (slotWr[g]) slotQ[g] <= regWdata;
    end
  end

  assign lowerQ   = slotQ[int'(SLOT_LOWER)];
  assign upperQ   = slotQ[int'(SLOT_UPPER)];
  assign regRdata = slotQ[regSel];

  assign inRange   = (chkAddr >= lowerQ) && (chkAddr < upperQ);
  assign chkPermit = chkValid && ((privMode_e'(chkMode) == PRIV_SUPER) || inRange);
  assign chkFault  = chkValid && !chkPermit;

  a_r2_lower_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrLower |=> lowerQ == $past(regWdata));

  a_r3_upper_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrUpper |=> upperQ == $past(regWdata));

  a_r5_deny_holds: assert property (@(posedge clk) disable iff (!rstN)
    strobe.denyWrite |=> ($stable(lowerQ) && $stable(upperQ)));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    chkValid |-> $onehot({chkPermit, chkFault}));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !chkValid |-> !(chkPermit || chkFault));

  a_r8_super_pass: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && chkMode) |-> chkPermit);

  a_r7_empty_region: assert property (@(posedge clk) disable iff (!rstN)
    (chkValid && !chkMode && (upperQ <= lowerQ)) |-> chkFault);
endmodule

// File: rtl/region_guard.sv
module region_guard
  import region_guard_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regReq,
  input  logic              regWrite,
  input  logic              regSel,
  input  logic              regMode,
  input  logic [ADDR_W-1:0] regWdata,
  output logic [ADDR_W-1:0] regRdata,
  output logic              privFault,
  input  logic              chkValid,
  input  logic              chkMode,
  input  logic [ADDR_W-1:0] chkAddr,
  output logic              chkPermit,
  output logic              chkFault
);
  regStrobe_t strobe;

  region_guard_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWrite(regWrite),
    .regSel(regSel), .regMode(regMode), .strobe(strobe), .privFault(privFault)
  );

  region_guard_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .chkValid(chkValid),
    .chkMode(chkMode), .chkAddr(chkAddr), .chkPermit(chkPermit),
    .chkFault(chkFault)
  );
endmodule

// File: tb/test_region_guard.sv
`timescale 1ns/1ps
module test_region_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regReq = 1'b0, regWrite = 1'b0, regSel = 1'b0, regMode = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        privFault;
  logic        chkValid = 1'b0, chkMode = 1'b0;
  logic [31:0] chkAddr = '0;
  logic        chkPermit, chkFault;

  int checks = 0;
  int errors = 0;
  logic [31:0] mLower = '0, mUpper = '0;

  always #2 clk = ~clk;

  region_guard i_region_guard (
    .clk(clk), .rstN(rstN), .regReq(regReq), .regWrite(regWrite),
    .regSel(regSel), .regMode(regMode), .regWdata(regWdata),
    .regRdata(regRdata), .privFault(privFault), .chkValid(chkValid),
    .chkMode(chkMode), .chkAddr(chkAddr), .chkPermit(chkPermit),
    .chkFault(chkFault)
  );

  function automatic logic expPermit(logic [31:0] a, logic m, logic [31:0] lo, logic [31:0] hi);
    return m || (a >= lo && a < hi);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive a check and compare in the same cycle
  task automatic doCheck(string req, logic [31:0] a, logic m);
    @(negedge clk);
    chkValid = 1'b1; chkAddr = a; chkMode = m;
    #1;
    check(req, {30'd0, chkPermit, chkFault},
          {30'd0, expPermit(a, m, mLower, mUpper), !expPermit(a, m, mLower, mUpper)});
    check("R6 pulse gone", {31'd0, privFault}, 32'd0);
    @(negedge clk);
    chkValid = 1'b0;
    #1;
    check("R9", {30'd0, chkPermit, chkFault}, 32'd0);
  endtask

  // register access; reads checked in-cycle, limit model updated after the edge
  task automatic regOp(logic w, logic s, logic [31:0] d, logic m);
    @(negedge clk);
    regReq = 1'b1; regWrite = w; regSel = s; regWdata = d; regMode = m;
    #1;
    check("R4 read", regRdata, s ? mUpper : mLower);
    @(negedge clk);
    regReq = 1'b0; regWrite = 1'b0;
    if (w && m) begin
      if (s) mUpper = d; else mLower = d;
    end
    #1;
    check("R6 pulse", {31'd0, privFault}, {31'd0, w && !m});
    check(s ? "R3/R5 value" : "R2/R5 value", s ? i_region_guard.regRdata : regRdata,
          s ? mUpper : mLower);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #9 rstN = 1'b1;
    // R1 reset state
    @(negedge clk); #1;
    check("R1 lower", regRdata, 32'd0);
    check("R1 fault", {31'd0, privFault}, 32'd0);
    doCheck("R1 user faults", 32'h0, 1'b0);
    doCheck("R1 user faults", 32'h1234, 1'b0);
    doCheck("R8 super", 32'hFFFF_FFFF, 1'b1);
    // R2 R3 set region
    regOp(1'b1, 1'b0, 32'h1000, 1'b1);
    regOp(1'b1, 1'b1, 32'h2000, 1'b1);
    // R7 edges
    doCheck("R7 at lower", 32'h1000, 1'b0);
    doCheck("R7 below", 32'h0FFF, 1'b0);
    doCheck("R7 last", 32'h1FFF, 1'b0);
    doCheck("R7 at upper", 32'h2000, 1'b0);
    // R5 R6 user writes refused
    regOp(1'b1, 1'b0, 32'h0, 1'b0);
    regOp(1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0);
    regOp(1'b0, 1'b1, 32'h0, 1'b0);
    doCheck("R5 region kept", 32'h1800, 1'b0);
    // R11 same-cycle write uses old limits
    @(negedge clk);
    regReq = 1'b1; regWrite = 1'b1; regSel = 1'b1; regWdata = 32'h3000; regMode = 1'b1;
    chkValid = 1'b1; chkAddr = 32'h2800; chkMode = 1'b0;
    #1;
    check("R11 old limits", {31'd0, chkPermit}, 32'd0);
    @(negedge clk);
    regReq = 1'b0; regWrite = 1'b0; mUpper = 32'h3000;
    #1;
    check("R11 new limits", {31'd0, chkPermit}, 32'd1);
    chkValid = 1'b0;
    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned pick = $urandom_range(0, 9);
      logic [31:0] a;
      if (pick < 2) begin
        regOp(1'b1, 1'($urandom_range(0, 1)), $urandom_range(0, 32'h4000), 1'($urandom_range(0, 1)));
      end else if (pick < 3) begin
        regOp(1'b0, 1'($urandom_range(0, 1)), 32'h0, 1'($urandom_range(0, 1)));
      end else begin
        a = (pick < 6) ? (mLower + 32'($urandom_range(0, 4)) - 32'd2)
          : (pick < 8) ? (mUpper + 32'($urandom_range(0, 4)) - 32'd2)
          : $urandom();
        doCheck(($urandom_range(0, 1) != 0) ? "R7 random" : "R10 random", a, 1'($urandom_range(0, 3) == 0));
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule